// File: doc/BRIEF.md
# Reloadable Table-Based Constant Multiplier

This block multiplies an unsigned multiplicand by a constant that is not built into the logic. The constant lives as precomputed products in small rewritable tables. The constant is cut into nibbles, and each constant nibble owns a table bank. A bank holds one 16-entry table for each input nibble. An entry is the product of its index and the bank's constant nibble. A bank joins its table outputs, weighting each by its input-nibble position, into a partial product one nibble wider than the input. The partial products are weighted by the position of their constant nibble and added into a result twice the input width.

Software changes the multiplier by giving a new constant with a one-cycle load strobe. A two-state controller (`ST_IDLE`, `ST_FILL`) then writes one table index per cycle into every table. It builds each entry by repeated addition of the constant nibble, so no multiplier is needed. The transitions are:
- *reset entry*: reset puts the controller in `ST_FILL` with the reset constant.
- *load accept*: `ST_IDLE` moves to `ST_FILL` when load is high.
- *fill done*: `ST_FILL` moves to `ST_IDLE` after writing the last index.

`busy` is high exactly while the controller is in `ST_FILL`. The multiply path has two register stages, and a valid flag travels with the data.

Top module: `lut_const_mult`

## Requirements
- R1: When `out_valid` is high, `out_product` equals the accepted `in_data` times the current constant, as an unsigned 16-bit value. This holds for every input from 0x00 to 0xFF and for the constants 0x00, 0x01 and 0xFF.
- R2: An input is accepted in a cycle where `in_valid` is high and `busy` is low. Its result appears with `out_valid` high exactly two cycles later. Back-to-back inputs give one result per cycle.
- R3: During reset, `busy` is high and `out_valid` is low. From the cycle reset is released, `busy` stays high for 16 cycles and then falls. After that the constant is 0xAB.
- R4: A load strobe seen while `busy` is low is accepted. `busy` rises in the next cycle and stays high for exactly 16 cycles. Results of inputs accepted afterwards use the new constant.
- R5: While `busy` is high, `out_valid` is low. `in_valid` asserted while `busy` is high never produces a result.
- R6: A load strobe seen while `busy` is high is ignored. The refill in progress keeps its constant, and its length is not extended.
- R7: An accepted load discards results still in flight. Inputs accepted in the load cycle or in the cycle before it produce no result. An input accepted two cycles before the load still produces its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Multiplicand present this cycle |
| in_data | input | 8 | Unsigned multiplicand |
| load | input | 1 | Strobe to take a new constant |
| load_const | input | 8 | New constant, taken with `load` |
| busy | output | 1 | Tables are being refilled |
| out_valid | output | 1 | `out_product` holds a result |
| out_product | output | 16 | Unsigned product |

## Verification
The bench builds the block with its default parameters: 8-bit data, 4-bit nibbles and the reset constant 0xAB. With these values each table has 16 entries. A full sweep of all 256 multiplicands therefore reads every entry of every table for a given constant. A refill takes only 16 cycles, so the bench can run many random reloads, inputs during refill, and loads that land next to in-flight data within a short run.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_t;

endpackage

// File: rtl/lcm_fill_fsm.sv
module lcm_fill_fsm
    import lcm_pkg::*;
#(
    parameter int unsigned          DATA_W      = 8,
    parameter int unsigned          NIB_W       = 4,
    parameter logic [DATA_W-1:0]    RESET_CONST = 'hAB,
    localparam int unsigned         NUM_NIB     = DATA_W / NIB_W,
    localparam int unsigned         ENT_W       = 2 * NIB_W,
    localparam int unsigned         DEPTH       = 1 << NIB_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [DATA_W-1:0]           load_const,
    output logic                        busy,
    output logic                        fill_start,
    output logic                        wr_en,
    output logic [NIB_W-1:0]            wr_idx,
    output logic [NUM_NIB*ENT_W-1:0]    wr_data
);

    localparam logic [NIB_W-1:0] LAST_IDX = NIB_W'(DEPTH - 1);

    fill_state_t                        state_q, state_d;
    logic [NIB_W-1:0]                   idx_q;
    logic [DATA_W-1:0]                  const_q;
    logic [NUM_NIB-1:0][ENT_W-1:0]      acc_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load)              state_d = ST_FILL;
            ST_FILL: if (idx_q == LAST_IDX) state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q == ST_FILL);
        wr_en      = (state_q == ST_FILL);
        fill_start = load && (state_q == ST_IDLE);
        wr_idx     = idx_q;
        wr_data    = acc_q;
    end

    // index and running entry values (entry = index * constant nibble)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            const_q <= RESET_CONST;
            idx_q   <= '0;
            acc_q   <= '0;
        end else if (fill_start) begin
            const_q <= load_const;
            idx_q   <= '0;
            acc_q   <= '0;
        end else if (state_q == ST_FILL) begin
            idx_q <= idx_q + 1'b1;
            for (int j = 0; j < int'(NUM_NIB); j++) begin
                acc_q[j] <= acc_q[j] + ENT_W'(const_q[j*NIB_W +: NIB_W]);
            end
        end
    end

    // R6: the constant being loaded does not change while busy
    assert_const_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(const_q));

    for (genvar j = 0; j < int'(NUM_NIB); j++) begin : g_entry_chk
        // R4: each written entry is its index times the constant nibble
        assert_fill_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> (acc_q[j] == ENT_W'(idx_q) * ENT_W'(const_q[j*NIB_W +: NIB_W])));
    end

endmodule

// File: rtl/lcm_table_bank.sv
module lcm_table_bank #(
    parameter int unsigned  DATA_W  = 8,
    parameter int unsigned  NIB_W   = 4,
    localparam int unsigned NUM_NIB = DATA_W / NIB_W,
    localparam int unsigned ENT_W   = 2 * NIB_W,
    localparam int unsigned DEPTH   = 1 << NIB_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [NIB_W-1:0]            wr_idx,
    input  logic [ENT_W-1:0]            wr_data,
    input  logic                        rd_en,
    input  logic [DATA_W-1:0]           x,
    output logic [NUM_NIB*ENT_W-1:0]    ent_q
);

    // one table per input nibble, all holding the same products
    for (genvar k = 0; k < int'(NUM_NIB); k++) begin : g_tab
        logic [ENT_W-1:0] tab [DEPTH];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int e = 0; e < int'(DEPTH); e++) tab[e] <= '0;
            end else if (wr_en) begin
                tab[wr_idx] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)     ent_q[k*ENT_W +: ENT_W] <= '0;
            else if (rd_en) ent_q[k*ENT_W +: ENT_W] <= tab[x[k*NIB_W +: NIB_W]];
        end
    end

    // R5: lookups never overlap a refill
    assert_no_read_in_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_en);

endmodule

// File: rtl/lcm_combine.sv
module lcm_combine #(
    parameter int unsigned  DATA_W  = 8,
    parameter int unsigned  NIB_W   = 4,
    localparam int unsigned NUM_NIB = DATA_W / NIB_W,
    localparam int unsigned ENT_W   = 2 * NIB_W,
    localparam int unsigned PP_W    = DATA_W + NIB_W,
    localparam int unsigned PROD_W  = 2 * DATA_W
) (
    input  logic [NUM_NIB*NUM_NIB*ENT_W-1:0]    ent_all,
    output logic [PROD_W-1:0]                   product
);

    logic [PP_W-1:0] pp [NUM_NIB];

    // per-bank partial product: table outputs weighted by input nibble position
    always_comb begin
        for (int j = 0; j < int'(NUM_NIB); j++) begin
            pp[j] = '0;
            for (int k = 0; k < int'(NUM_NIB); k++) begin
                pp[j] = pp[j] + (PP_W'(ent_all[(j*NUM_NIB + k)*ENT_W +: ENT_W]) << (k*NIB_W));
            end
        end
    end

    // final adder: partial products weighted by constant nibble position
    always_comb begin
        product = '0;
        for (int j = 0; j < int'(NUM_NIB); j++) begin
            product = product + (PROD_W'(pp[j]) << (j*NIB_W));
        end
    end

endmodule

// File: rtl/lut_const_mult.sv
module lut_const_mult #(
    parameter int unsigned          DATA_W      = 8,
    parameter int unsigned          NIB_W       = 4,
    parameter logic [DATA_W-1:0]    RESET_CONST = 'hAB,
    localparam int unsigned         NUM_NIB     = DATA_W / NIB_W,
    localparam int unsigned         ENT_W       = 2 * NIB_W,
    localparam int unsigned         PROD_W      = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                load,
    input  logic [DATA_W-1:0]   load_const,
    output logic                busy,
    output logic                out_valid,
    output logic [PROD_W-1:0]   out_product
);

    logic                               fill_start;
    logic                               wr_en;
    logic [NIB_W-1:0]                   wr_idx;
    logic [NUM_NIB*ENT_W-1:0]           wr_data;
    logic                               rd_en;
    logic [NUM_NIB*NUM_NIB*ENT_W-1:0]   ent_all;
    logic [PROD_W-1:0]                  sum;
    logic                               v1_q;
    logic                               vout_q;
    logic [PROD_W-1:0]                  prod_q;

    lcm_fill_fsm #(
        .DATA_W      (DATA_W),
        .NIB_W       (NIB_W),
        .RESET_CONST (RESET_CONST)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_const (load_const),
        .busy       (busy),
        .fill_start (fill_start),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data)
    );

    assign rd_en = in_valid && !busy;

    for (genvar j = 0; j < int'(NUM_NIB); j++) begin : g_bank
        lcm_table_bank #(
            .DATA_W (DATA_W),
            .NIB_W  (NIB_W)
        ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_idx  (wr_idx),
            .wr_data (wr_data[j*ENT_W +: ENT_W]),
            .rd_en   (rd_en),
            .x       (in_data),
            .ent_q   (ent_all[j*NUM_NIB*ENT_W +: NUM_NIB*ENT_W])
        );
    end

    lcm_combine #(
        .DATA_W (DATA_W),
        .NIB_W  (NIB_W)
    ) i_combine (
        .ent_all (ent_all),
        .product (sum)
    );

    // stage 1 valid follows the table read; stage 2 holds the sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q   <= 1'b0;
            vout_q <= 1'b0;
            prod_q <= '0;
        end else begin
            v1_q   <= rd_en;
            vout_q <= v1_q && !busy && !fill_start;
            if (v1_q) prod_q <= sum;
        end
    end

    assign out_valid   = vout_q;
    assign out_product = prod_q;

    // R5: no result while the tables refill
    assert_no_result_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !out_valid);

    // R2: every result comes from an input two cycles earlier
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R4: an accepted load raises busy on the next cycle
    assert_load_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> busy);

endmodule

// File: tb/test_lut_const_mult.sv
`timescale 1ns/1ps
module test_lut_const_mult;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        load;
    logic [7:0]  load_const;
    logic        busy;
    logic        out_valid;
    logic [15:0] out_product;

    always #4 clk = ~clk;

    lut_const_mult i_lut_const_mult (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .load        (load),
        .load_const  (load_const),
        .busy        (busy),
        .out_valid   (out_valid),
        .out_product (out_product)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;
    string       tag      = "R3";

    // reference model state
    int          m_left;
    logic [7:0]  m_const;
    logic [7:0]  m_pend;
    logic        s1_v, s2_v;
    logic [15:0] s1_p, s2_p;

    function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        return 16'(a) * 16'(b);
    endfunction

    task automatic step(input logic v, input logic [7:0] x,
                        input logic ld, input logic [7:0] c);
        logic bsy, acc;
        @(negedge clk);
        n_checks++;
        if (busy !== (m_left > 0)) begin
            n_fail++;
            $display("FAIL %s busy got %0b exp %0b", tag, busy, (m_left > 0));
        end
        n_checks++;
        if (out_valid !== s2_v) begin
            n_fail++;
            $display("FAIL %s out_valid got %0b exp %0b", tag, out_valid, s2_v);
        end
        if (s2_v) begin
            n_checks++;
            if (out_product !== s2_p) begin
                n_fail++;
                $display("FAIL R1 (%s) product got %h exp %h", tag, out_product, s2_p);
            end
        end
        in_valid   = v;
        in_data    = x;
        load       = ld;
        load_const = c;
        bsy  = (m_left > 0);
        acc  = ld && !bsy;
        s2_v = s1_v && !acc && !bsy;
        s2_p = s1_p;
        s1_v = v && !bsy;
        s1_p = ref_mul(x, m_const);
        if (acc) begin
            m_left = 16;
            m_pend = c;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) m_const = m_pend;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic sweep();
        for (int i = 0; i < 256; i++) step(1'b1, 8'(i), 1'b0, 8'h00);
        idle(3);
    endtask

    task automatic reload(input logic [7:0] c);
        step(1'b0, 8'h00, 1'b1, c);
        idle(17);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; load = 1'b0; load_const = '0;
        void'($urandom(32'd1234));
        // R3: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_checks++;
            if (busy !== 1'b1 || out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R3 reset busy/out_valid got %0b/%0b exp 1/0", busy, out_valid);
            end
        end
        @(negedge clk);
        rst_n  = 1'b1;
        m_left = 15; m_pend = 8'hAB; m_const = 8'h00;
        s1_v = 1'b0; s2_v = 1'b0; s1_p = '0; s2_p = '0;
        tag = "R3"; idle(18);
        tag = "R1"; sweep();                       // reset constant 0xAB, all inputs
        // R4: reload and use new constants, including boundaries
        tag = "R4"; reload(8'hFF); sweep();
        tag = "R4"; reload(8'h00); sweep();
        tag = "R4"; reload(8'h01); sweep();
        // R5: inputs during a refill are dropped
        tag = "R5";
        step(1'b0, 8'h00, 1'b1, 8'h3C);
        for (int i = 0; i < 20; i++) step(1'b1, 8'($urandom), 1'b0, 8'h00);
        idle(3);
        // R6: loads during a refill are ignored
        tag = "R6";
        step(1'b0, 8'h00, 1'b1, 8'h37);
        for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 1'b1, 8'hC4);
        idle(10);
        sweep();
        // R7: loads discard results still in flight
        tag = "R7";
        step(1'b1, 8'h9E, 1'b0, 8'h00);
        step(1'b1, 8'h42, 1'b0, 8'h00);
        step(1'b1, 8'hE7, 1'b1, 8'h5A);
        idle(20);
        step(1'b1, 8'hFF, 1'b0, 8'h00);
        idle(3);
        // R2: constrained random traffic with sparse reloads
        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            logic v, ld;
            v  = ($urandom % 4) != 0;
            ld = ($urandom % 60) == 0;
            step(v, 8'($urandom), ld, 8'($urandom));
        end
        idle(20);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired in phase %s", tag);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule